// File: doc/BRIEF.md
# Single-Precision Flush-to-Zero Floating-Point Multiplier

This block multiplies two IEEE-754 single-precision operands in a three-stage pipeline for the execute unit of a small CPU. It rounds to nearest, with ties to even. Values below the normal range are not represented. A denormal operand is read as a zero of its own sign. A product whose exponent falls under the normal range becomes a signed zero. Every NaN the block produces is the single pattern 0x7FFFFFFF.

With each operation the block returns six status bits and a write enable for the destination register. The caller supplies a six-bit enable mask together with the operands. When a status bit is raised and its enable bit is also set, the write enable stays low, so the register file keeps its old value and the surrounding trap logic can take over. An enabled denormal operand stops the operation at once: only the denormal bit is reported, whatever else the operands contain. The status bits belong to one operation only. Any accumulation across operations is done outside the block.

Input is a valid strobe with no ready signal, and the block never applies back-pressure. It accepts one operation on every clock. The result appears exactly three clocks later, and the consumer must take it in that cycle.

Top module: `fpu_mul_ftz`

## Requirements
- R1: An operation presented with `in_valid` high at a rising edge produces `out_valid` high for one cycle, after the third rising edge that follows. Operations can be issued on consecutive cycles, and each one comes out in order with the same latency.
- R2: For normal operands, `out_result` is the product rounded to nearest with ties to even, from a guard bit and a sticky bit. Status bit 0 (inexact) is set exactly when a discarded bit is nonzero. Infinity times a nonzero finite value gives infinity, and zero times a finite value gives zero, each with the XOR of the operand signs.
- R3: If the rounded exponent reaches 255, the result is infinity with the product sign, and status bits 2 (overflow) and 0 (inexact) are set.
- R4: If the unrounded exponent of a finite nonzero product is 0 or below, the result is zero with the product sign, and status bits 1 (underflow) and 0 (inexact) are set. The smallest normal value, 0x00800000, is still produced as is.
- R5: A denormal operand (exponent field 0, fraction nonzero) sets status bit 5. When enable bit 5 is clear, the operand counts as a zero of its own sign, and the write proceeds unless another enabled bit is raised.
- R6: If a denormal operand is present and enable bit 5 is set, then `out_we` is low, `out_flags` is exactly 0x20 and `out_result` is 0x00000000, regardless of NaN or infinity operands.
- R7: Whenever either operand is a NaN, the result is 0x7FFFFFFF. No other NaN pattern ever appears on `out_result`.
- R8: Status bit 4 (invalid) is set when an operand is a signalling NaN (fraction bit 22 clear) or when the operation is zero times infinity, including a zero that came from a flushed denormal. The result is then 0x7FFFFFFF.
- R9: While `out_valid` is high, `out_we` is high exactly when `out_flags & exc_en` (the mask given with that operation) is zero. While `out_valid` is low, `out_we` is low.
- R10: Status bit 3 (divide by zero) is never set by this block.
- R11: While `rst_n` is low, `out_valid` and `out_we` are low. Operations in flight when reset is asserted are discarded.
- R12: `out_result` never holds a denormal encoding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| exc_en | input | 6 | Per-operation exception enable mask, same bit order as `out_flags` |
| out_valid | output | 1 | Result strobe, three cycles after `in_valid` |
| out_result | output | 32 | Product |
| out_we | output | 1 | Destination write enable |
| out_flags | output | 6 | Status: 0 inexact, 1 underflow, 2 overflow, 3 divide by zero, 4 invalid, 5 denormal operand |

## Verification
The properties assume that `in_valid` and `exc_en` are defined at every rising edge outside reset. They also assume that the mask applying to an operation is the value sampled alongside its `in_valid`, which is why the checker delays the mask by three cycles itself. The bench changes inputs only on falling edges and never drives an unknown value. It covers the operand classes that reach each property: NaNs, infinities, zeros, denormals, and products on both sides of the overflow and underflow thresholds. It runs each vector once on its own and once back to back, and it also asserts reset while operations are in flight.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int MANT_W = FRAC_W + 1;
  localparam int PROD_W = 2 * MANT_W;
  localparam int SE_W   = EXP_W + 2;
  localparam int N_OPS  = 2;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

  localparam int EXC_W   = 6;
  localparam int EXC_INX = 0;
  localparam int EXC_UNF = 1;
  localparam int EXC_OVF = 2;
  localparam int EXC_DVZ = 3;
  localparam int EXC_INV = 4;
  localparam int EXC_DEN = 5;

  localparam logic [EXP_W-1:0]         EXP_ONES  = '1;
  localparam logic signed [SE_W-1:0]   E_TOP     = SE_W'((1 << EXP_W) - 1);
  localparam logic signed [SE_W-1:0]   E_NIL     = '0;
  localparam logic [WORD_W-1:0]        QNAN_WORD = {1'b0, {(WORD_W-1){1'b1}}};

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [MANT_W-1:0] mant;
    logic              zero;
    logic              inf;
    logic              nan;
    logic              snan;
    logic              den;
  } opnd_t;

  typedef enum logic [1:0] {K_NUM, K_ZERO, K_INF, K_NAN} kind_e;
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
  import fpm_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output opnd_t             info
);
  logic [EXP_W-1:0]  e;
  logic [FRAC_W-1:0] f;

  always_comb begin
    e         = word[WORD_W-2:FRAC_W];
    f         = word[FRAC_W-1:0];
    info.sign = word[WORD_W-1];
    info.exp  = e;
    // a denormal is flushed: it reads as zero with its own sign
    info.den  = (e == '0) && (f != '0);
    info.zero = (e == '0);
    info.inf  = (e == EXP_ONES) && (f == '0);
    info.nan  = (e == EXP_ONES) && (f != '0);
    info.snan = info.nan && !f[FRAC_W-1];
    info.mant = {(e != '0), f};
  end
endmodule

// File: rtl/fpm_mulcore.sv
module fpm_mulcore
  import fpm_pkg::*;
(
  input  opnd_t                   a,
  input  opnd_t                   b,
  output logic                    sign,
  output kind_e                   kind,
  output logic signed [SE_W-1:0]  exp_sum,
  output logic [PROD_W-1:0]       prod,
  output logic                    invalid,
  output logic                    den_in
);
  logic any_nan;
  logic zero_inf;

  always_comb begin
    sign     = a.sign ^ b.sign;
    prod     = PROD_W'(a.mant) * PROD_W'(b.mant);
    exp_sum  = $signed({2'b00, a.exp}) + $signed({2'b00, b.exp}) - SE_W'(BIAS);
    any_nan  = a.nan | b.nan;
    zero_inf = (a.inf & b.zero) | (a.zero & b.inf);
    invalid  = a.snan | b.snan | zero_inf;
    den_in   = a.den | b.den;
    if (any_nan || zero_inf)  kind = K_NAN;
    else if (a.inf || b.inf)  kind = K_INF;
    else if (a.zero || b.zero) kind = K_ZERO;
    else                      kind = K_NUM;
  end
endmodule

// File: rtl/fpm_round.sv
module fpm_round
  import fpm_pkg::*;
(
  input  logic                   sign,
  input  kind_e                  kind,
  input  logic signed [SE_W-1:0] exp_sum,
  input  logic [PROD_W-1:0]      prod,
  output logic [WORD_W-1:0]      word,
  output logic                   inexact,
  output logic                   overflow,
  output logic                   underflow
);
  logic                   hi;
  logic [MANT_W-1:0]      keep;
  logic                   g;
  logic                   st;
  logic                   up;
  logic [MANT_W:0]        rnd;
  logic [FRAC_W-1:0]      frac_out;
  logic signed [SE_W-1:0] e_pre;
  logic signed [SE_W-1:0] e_post;

  always_comb begin
    hi       = prod[PROD_W-1];
    keep     = hi ? prod[PROD_W-1 -: MANT_W] : prod[PROD_W-2 -: MANT_W];
    g        = hi ? prod[MANT_W-1] : prod[MANT_W-2];
    st       = hi ? |prod[MANT_W-2:0] : |prod[MANT_W-3:0];
    e_pre    = exp_sum + {{(SE_W-1){1'b0}}, hi};
    up       = g & (st | keep[0]);
    rnd      = {1'b0, keep} + {{MANT_W{1'b0}}, up};
    e_post   = e_pre + {{(SE_W-1){1'b0}}, rnd[MANT_W]};
    frac_out = rnd[MANT_W] ? '0 : rnd[FRAC_W-1:0];

    word      = '0;
    inexact   = 1'b0;
    overflow  = 1'b0;
    underflow = 1'b0;
    unique case (kind)
      K_NAN:  word = QNAN_WORD;
      K_INF:  word = {sign, EXP_ONES, {FRAC_W{1'b0}}};
      K_ZERO: word = {sign, {(WORD_W-1){1'b0}}};
      default: begin
        if (e_pre <= E_NIL) begin
          word      = {sign, {(WORD_W-1){1'b0}}};
          underflow = 1'b1;
          inexact   = 1'b1;
        end else if (e_post >= E_TOP) begin
          word      = {sign, EXP_ONES, {FRAC_W{1'b0}}};
          overflow  = 1'b1;
          inexact   = 1'b1;
        end else begin
          word      = {sign, e_post[EXP_W-1:0], frac_out};
          inexact   = g | st;
        end
      end
    endcase
  end
endmodule

// File: rtl/fpu_mul_ftz.sv
module fpu_mul_ftz
  import fpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  input  logic [EXC_W-1:0]  exc_en,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_result,
  output logic              out_we,
  output logic [EXC_W-1:0]  out_flags
);
  // stage 1: classify operands
  logic [WORD_W-1:0] in_w [N_OPS];
  opnd_t             op_c [N_OPS];
  opnd_t             op_q [N_OPS];
  logic              v1;
  logic [EXC_W-1:0]  en1;

  assign in_w[0] = in_a;
  assign in_w[1] = in_b;

  generate
    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_unpack
      fpm_unpack u_unpack (.word(in_w[gi]), .info(op_c[gi]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) v1 <= 1'b0;
    else        v1 <= in_valid;

  always_ff @(posedge clk) begin
    en1 <= exc_en;
    for (int i = 0; i < N_OPS; i++) op_q[i] <= op_c[i];
  end

  // stage 2: significand product, exponent sum, special cases
  logic                   sign_c, inv_c, den_c;
  kind_e                  kind_c;
  logic signed [SE_W-1:0] exp_c;
  logic [PROD_W-1:0]      prod_c;

  fpm_mulcore u_core (
    .a(op_q[0]), .b(op_q[1]), .sign(sign_c), .kind(kind_c),
    .exp_sum(exp_c), .prod(prod_c), .invalid(inv_c), .den_in(den_c)
  );

  logic                   v2, sign2, inv2, den2;
  kind_e                  kind2;
  logic signed [SE_W-1:0] exp2;
  logic [PROD_W-1:0]      prod2;
  logic [EXC_W-1:0]       en2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) v2 <= 1'b0;
    else        v2 <= v1;

  always_ff @(posedge clk) begin
    sign2 <= sign_c;
    kind2 <= kind_c;
    exp2  <= exp_c;
    prod2 <= prod_c;
    inv2  <= inv_c;
    den2  <= den_c;
    en2   <= en1;
  end

  // stage 3: normalise, round, gate the write
  logic [WORD_W-1:0] word_c;
  logic              inx_c, ovf_c, unf_c;
  logic              abort_c;
  logic [EXC_W-1:0]  flags_c;
  logic [WORD_W-1:0] res_c;
  logic              we_c;

  fpm_round u_round (
    .sign(sign2), .kind(kind2), .exp_sum(exp2), .prod(prod2),
    .word(word_c), .inexact(inx_c), .overflow(ovf_c), .underflow(unf_c)
  );

  always_comb begin
    abort_c = den2 & en2[EXC_DEN];
    flags_c = '0;
    res_c   = word_c;
    if (abort_c) begin
      flags_c[EXC_DEN] = 1'b1;
      res_c            = '0;
    end else begin
      flags_c[EXC_INX] = inx_c;
      flags_c[EXC_UNF] = unf_c;
      flags_c[EXC_OVF] = ovf_c;
      flags_c[EXC_INV] = inv2;
      flags_c[EXC_DEN] = den2;
    end
    we_c = v2 && ((flags_c & en2) == '0);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_we    <= 1'b0;
    end else begin
      out_valid <= v2;
      out_we    <= we_c;
    end

  always_ff @(posedge clk) begin
    out_result <= res_c;
    out_flags  <= flags_c;
  end
endmodule

// File: rtl/fpu_mul_ftz_chk.sv
module fpu_mul_ftz_chk
  import fpm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [EXC_W-1:0]  exc_en,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_result,
  input logic              out_we,
  input logic [EXC_W-1:0]  out_flags
);
  logic [2:0]       v_d;
  logic [EXC_W-1:0] en_d0, en_d1, en_d2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v_d   <= '0;
      en_d0 <= '0;
      en_d1 <= '0;
      en_d2 <= '0;
    end else begin
      v_d   <= {v_d[1:0], in_valid};
      en_d0 <= exc_en;
      en_d1 <= en_d0;
      en_d2 <= en_d1;
    end

  logic [EXP_W-1:0]  r_exp;
  logic [FRAC_W-1:0] r_frac;
  assign r_exp  = out_result[WORD_W-2:FRAC_W];
  assign r_frac = out_result[FRAC_W-1:0];

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == v_d[2]);

  p_overflow_inf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags[EXC_OVF] |-> (r_exp == EXP_ONES) && (r_frac == '0) && out_flags[EXC_INX]);

  p_underflow_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags[EXC_UNF] |-> (out_result[WORD_W-2:0] == '0) && out_flags[EXC_INX]);

  p_den_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags[EXC_DEN] && !en_d2[EXC_DEN]
      |-> (out_result[WORD_W-2:0] == '0) || (out_result == QNAN_WORD));

  p_den_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags[EXC_DEN] && en_d2[EXC_DEN]
      |-> !out_we && (out_flags == EXC_W'(1 << EXC_DEN)) && (out_result == '0));

  p_nan_pattern_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (r_exp == EXP_ONES) && (r_frac != '0) |-> out_result == QNAN_WORD);

  p_invalid_nan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags[EXC_INV] |-> out_result == QNAN_WORD);

  p_write_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_we == ((out_flags & en_d2) == '0));

  p_no_stray_we_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_we);

  p_no_divzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_flags[EXC_DVZ]);

  p_no_denormal_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !((r_exp == '0) && (r_frac != '0)));
endmodule

bind fpu_mul_ftz fpu_mul_ftz_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .exc_en(exc_en),
  .out_valid(out_valid), .out_result(out_result), .out_we(out_we), .out_flags(out_flags)
);

// File: tb/fpu_mul_ftz_tb.sv
module fpu_mul_ftz_tb;
  import fpm_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic              in_valid;
  logic [31:0]       in_a, in_b;
  logic [5:0]        exc_en;
  logic              out_valid, out_we;
  logic [31:0]       out_result;
  logic [5:0]        out_flags;

  fpu_mul_ftz u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .exc_en(exc_en), .out_valid(out_valid), .out_result(out_result),
    .out_we(out_we), .out_flags(out_flags)
  );

  typedef struct packed {
    int          req;
    logic [31:0] a;
    logic [31:0] b;
    logic [5:0]  en;
    logic [31:0] res;
    logic [5:0]  fl;
    logic        we;
  } vec_t;

  localparam int NV = 29;
  // flags: 5 den, 4 inv, 3 dvz, 2 ovf, 1 unf, 0 inx
  localparam vec_t VECS [NV] = '{
    '{2,  32'h3F800000, 32'h3F800000, 6'h00, 32'h3F800000, 6'h00, 1'b1}, // R2 1*1
    '{2,  32'h3FC00000, 32'h40000000, 6'h00, 32'h40400000, 6'h00, 1'b1}, // R2 1.5*2
    '{2,  32'hC0000000, 32'h40400000, 6'h00, 32'hC0C00000, 6'h00, 1'b1}, // R2 sign
    '{2,  32'h3F800001, 32'h3F800001, 6'h00, 32'h3F800002, 6'h01, 1'b1}, // R2 sticky only
    '{2,  32'h3F800001, 32'h3FC00000, 6'h00, 32'h3FC00002, 6'h01, 1'b1}, // R2 tie, odd -> up
    '{2,  32'h3F800003, 32'h3FC00000, 6'h00, 32'h3FC00004, 6'h01, 1'b1}, // R2 tie, even stays
    '{2,  32'h7F7FFFFF, 32'h3F800000, 6'h00, 32'h7F7FFFFF, 6'h00, 1'b1}, // R2 largest normal
    '{3,  32'h7F000000, 32'h40000000, 6'h00, 32'h7F800000, 6'h05, 1'b1}, // R3
    '{3,  32'hFF000000, 32'h40000000, 6'h00, 32'hFF800000, 6'h05, 1'b1}, // R3 negative
    '{4,  32'h00800000, 32'h3F000000, 6'h00, 32'h00000000, 6'h03, 1'b1}, // R4
    '{4,  32'h80800000, 32'h3F000000, 6'h00, 32'h80000000, 6'h03, 1'b1}, // R4 negative
    '{4,  32'h00800000, 32'h3F800000, 6'h00, 32'h00800000, 6'h00, 1'b1}, // R4 smallest normal
    '{4,  32'h00FFFFFF, 32'h3F000000, 6'h00, 32'h00000000, 6'h03, 1'b1}, // R4 R12 exact but subnormal
    '{5,  32'h00000001, 32'h3F800000, 6'h00, 32'h00000000, 6'h20, 1'b1}, // R5
    '{5,  32'h80400000, 32'h40000000, 6'h00, 32'h80000000, 6'h20, 1'b1}, // R5 signed zero
    '{6,  32'h00400000, 32'h3F800000, 6'h20, 32'h00000000, 6'h20, 1'b0}, // R6
    '{6,  32'h00400000, 32'h7FC00000, 6'h20, 32'h00000000, 6'h20, 1'b0}, // R6 beats NaN
    '{8,  32'h00400000, 32'h7F800000, 6'h00, 32'h7FFFFFFF, 6'h30, 1'b1}, // R8 flushed zero * inf
    '{7,  32'h7FC00001, 32'h3F800000, 6'h00, 32'h7FFFFFFF, 6'h00, 1'b1}, // R7
    '{7,  32'hFFC00000, 32'h40000000, 6'h00, 32'h7FFFFFFF, 6'h00, 1'b1}, // R7 negative NaN
    '{8,  32'h7F800001, 32'h3F800000, 6'h00, 32'h7FFFFFFF, 6'h10, 1'b1}, // R8 signalling
    '{8,  32'h00000000, 32'hFF800000, 6'h00, 32'h7FFFFFFF, 6'h10, 1'b1}, // R8 zero * inf
    '{2,  32'h7F800000, 32'hC0000000, 6'h00, 32'hFF800000, 6'h00, 1'b1}, // R2 inf * finite
    '{2,  32'h80000000, 32'h40000000, 6'h00, 32'h80000000, 6'h00, 1'b1}, // R2 zero * finite
    '{9,  32'h3F800001, 32'h3F800001, 6'h01, 32'h3F800002, 6'h01, 1'b0}, // R9 inexact enabled
    '{9,  32'h7F000000, 32'h40000000, 6'h04, 32'h7F800000, 6'h05, 1'b0}, // R9 overflow enabled
    '{9,  32'h3F800000, 32'h3F800000, 6'h3F, 32'h3F800000, 6'h00, 1'b1}, // R9 all enabled, none raised
    '{7,  32'h7F800000, 32'h7FC00000, 6'h00, 32'h7FFFFFFF, 6'h00, 1'b1}, // R7 inf * NaN
    '{5,  32'h00000001, 32'h3F800000, 6'h01, 32'h00000000, 6'h20, 1'b1}  // R5 other enable only
  };

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_vec(input int i);
    string rq;
    rq = $sformatf("R%0d", VECS[i].req);
    check(out_valid === 1'b1, "R1", $sformatf("valid vec %0d", i), 32'(out_valid), 32'h1);
    check(out_result === VECS[i].res, rq, $sformatf("result vec %0d", i), out_result, VECS[i].res);
    check(out_flags === VECS[i].fl, rq, $sformatf("flags vec %0d", i), 32'(out_flags), 32'(VECS[i].fl));
    check(out_we === VECS[i].we, rq, $sformatf("we vec %0d", i), 32'(out_we), 32'(VECS[i].we));
    // R10: divide-by-zero bit never raised
    check(out_flags[3] === 1'b0, "R10", $sformatf("dvz vec %0d", i), 32'(out_flags[3]), 32'h0);
    // R12: no subnormal encoding on the result
    check(!(out_result[30:23] == 8'h00 && out_result[22:0] != 23'h0), "R12",
          $sformatf("subnormal vec %0d", i), out_result, 32'h0);
  endtask

  task automatic drive(input int i);
    in_valid = 1'b1;
    in_a     = VECS[i].a;
    in_b     = VECS[i].b;
    exc_en   = VECS[i].en;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_a     = '0;
    in_b     = '0;
    exc_en   = '0;
    repeat (3) @(negedge clk);
    // R11: quiet outputs in reset
    check(out_valid === 1'b0, "R11", "valid in reset", 32'(out_valid), 32'h0);
    check(out_we === 1'b0, "R11", "we in reset", 32'(out_we), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // isolated operations, latency checked on the cycles before the result
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(i);
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid === 1'b0, "R1", "early valid +1", 32'(out_valid), 32'h0);
      @(negedge clk);
      check(out_valid === 1'b0, "R1", "early valid +2", 32'(out_valid), 32'h0);
      @(negedge clk);
      check_vec(i);
    end

    // back-to-back stream, R1 throughput
    for (int c = 0; c < NV + 3; c++) begin
      @(negedge clk);
      if (c >= 3) check_vec(c - 3);
      if (c < NV) drive(c);
      else in_valid = 1'b0;
    end
    @(negedge clk);
    check(out_valid === 1'b0, "R1", "valid after stream", 32'(out_valid), 32'h0);

    // R11: reset while operations are in flight
    drive(0);
    @(negedge clk);
    drive(1);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n    = 1'b0;
    #1;
    check(out_valid === 1'b0, "R11", "valid at reset", 32'(out_valid), 32'h0);
    check(out_we === 1'b0, "R11", "we at reset", 32'(out_we), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(out_valid === 1'b0, "R11", "flushed op", 32'(out_valid), 32'h0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule